// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

The block watches a serial bit stream, taking one bit per clock, and raises a match flag as soon as the newest bits form either the rising pattern 0111 or the falling pattern 1000. The two patterns are mirror images of each other. Each is one bit of one value followed by three bits of the other value.

The flag is a Mealy output. It is decoded from the stored state together with the bit currently on the input, so a match is signalled in the same cycle the completing bit is presented. The bit is consumed at the next rising clock edge. Matches may overlap: the last bit of one match can serve as the first bit of the next one.

The stored state does not hold a shift history. It keeps three things:
- the value of the current run of equal bits;
- the length of that run, saturating at three;
- whether the run was started by a change of value rather than by reset.

The pattern length is a parameter. The run limit and the counter width are derived from it.

Top module: `seqdet_dual_mealy`

## Requirements
- R1: While `rst_ni` is low, `z_o` is 0 whatever the value of `x_i`.
- R2: `z_o` is 1 whenever the three bits consumed most recently since reset, oldest first, followed by the present `x_i`, read 0,1,1,1.
- R3: `z_o` is 1 whenever the three bits consumed most recently since reset, oldest first, followed by the present `x_i`, read 1,0,0,0.
- R4: `z_o` is 0 in every other case, including runs of four or more equal bits such as 0,1,1,1,1.
- R5: Matches may overlap. The stream 0,1,1,1,0,0,0 gives `z_o` = 1 on its fourth and seventh bits, because the fourth bit is shared by both matches.
- R6: `z_o` follows `x_i` within a cycle, without waiting for a clock edge. With the state holding 0,1,1, setting `x_i` to 1 then 0 then 1 gives `z_o` = 1, then 0, then 1.
- R7: `z_o` is never 1 in two consecutive cycles.
- R8: Bits consumed before the most recent reset never contribute to a match. For example, 1,1,1 after reset gives no match, and 0,1,1 then reset then 1 gives no match.
- R9: Starting from reset, the input stream 0000111000 produces the output stream 0000001001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; `x_i` is consumed on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the bit history |
| x_i | input | 1 | Serial data bit |
| z_o | output | 1 | Match flag, combinational from the state and `x_i` |

## Verification
The checker samples `x_i` only at rising clock edges. It therefore assumes that `x_i` is stable around each edge, and that the value present just before an edge is the bit that edge consumes.

The bench drives `x_i` shortly after each rising edge and reads `z_o` well before the next one. The one deliberate mid-cycle toggle of `x_i` is settled before the edge arrives.

Reset is released between edges. The checker's own history and the design state are therefore cleared together, and no property is evaluated across the release.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int unsigned SEQ_LEN_DEF = 4;

  typedef enum logic {
    BIT_LO = 1'b0,
    BIT_HI = 1'b1
  } run_bit_e;
endpackage

// File: rtl/seqdet_run_tracker.sv
module seqdet_run_tracker
  import seqdet_pkg::*;
#(
  parameter int unsigned RUN_MAX = 3,
  localparam int unsigned CNT_W = $clog2(RUN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             x_i,
  output run_bit_e         run_bit_o,
  output logic [CNT_W-1:0] run_len_o,
  output logic             anchored_o
);

  run_bit_e         bit_q, bit_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             anc_q, anc_d;

  always_comb begin
    bit_d = bit_q;
    len_d = len_q;
    anc_d = anc_q;
    if (len_q == '0) begin
      // first bit after reset: a run with no known predecessor
      bit_d = run_bit_e'(x_i);
      len_d = CNT_W'(1);
      anc_d = 1'b0;
    end else if (x_i == logic'(bit_q)) begin
      if (len_q != CNT_W'(RUN_MAX)) len_d = len_q + 1'b1;
    end else begin
      bit_d = run_bit_e'(x_i);
      len_d = CNT_W'(1);
      anc_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= BIT_LO;
      len_q <= '0;
      anc_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      len_q <= len_d;
      anc_q <= anc_d;
    end
  end

  assign run_bit_o  = bit_q;
  assign run_len_o  = len_q;
  assign anchored_o = anc_q;

endmodule

// File: rtl/seqdet_match_decode.sv
module seqdet_match_decode
  import seqdet_pkg::*;
#(
  parameter int unsigned RUN_MAX = 3,
  localparam int unsigned CNT_W = $clog2(RUN_MAX + 1)
) (
  input  logic             x_i,
  input  run_bit_e         run_bit_i,
  input  logic [CNT_W-1:0] run_len_i,
  input  logic             anchored_i,
  output logic             z_o
);

  logic [1:0] hit;

  // pattern g: one bit of ~g, then RUN_MAX bits of g; fires on the last one
  for (genvar g = 0; g < 2; g++) begin : g_pat
    assign hit[g] = anchored_i
                 && (run_len_i == CNT_W'(RUN_MAX - 1))
                 && (logic'(run_bit_i) == 1'(g))
                 && (x_i == 1'(g));
  end

  assign z_o = |hit;

endmodule

// File: rtl/seqdet_dual_mealy.sv
module seqdet_dual_mealy
  import seqdet_pkg::*;
#(
  parameter int unsigned SEQ_LEN = SEQ_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);

  localparam int unsigned RUN_MAX = SEQ_LEN - 1;
  localparam int unsigned CNT_W   = $clog2(RUN_MAX + 1);

  run_bit_e         run_bit;
  logic [CNT_W-1:0] run_len;
  logic             anchored;

  seqdet_run_tracker #(.RUN_MAX(RUN_MAX)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x_i        (x_i),
    .run_bit_o  (run_bit),
    .run_len_o  (run_len),
    .anchored_o (anchored)
  );

  seqdet_match_decode #(.RUN_MAX(RUN_MAX)) u_dec (
    .x_i        (x_i),
    .run_bit_i  (run_bit),
    .run_len_i  (run_len),
    .anchored_i (anchored),
    .z_o        (z_o)
  );

endmodule

// File: rtl/seqdet_dual_mealy_chk.sv
module seqdet_dual_mealy_chk #(
  parameter int unsigned SEQ_LEN = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic x_i,
  input logic z_o
);

  localparam int unsigned HW = SEQ_LEN - 1;
  localparam int unsigned FW = $clog2(SEQ_LEN);
  localparam logic [SEQ_LEN-1:0] RISE_PAT = {1'b0, {HW{1'b1}}};
  localparam logic [SEQ_LEN-1:0] FALL_PAT = {1'b1, {HW{1'b0}}};

  logic [HW-1:0] hist_q;
  logic [FW-1:0] fill_q;
  logic          full;
  logic [SEQ_LEN-1:0] window;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= {hist_q[HW-2:0], x_i};
      if (fill_q != FW'(HW)) fill_q <= fill_q + 1'b1;
    end
  end

  assign full   = (fill_q == FW'(HW));
  assign window = {hist_q, x_i};

  AST_RISE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && window == RISE_PAT) |-> z_o);  // R2
  AST_FALL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && window == FALL_PAT) |-> z_o);  // R3
  AST_NO_FALSE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |-> (full && (window == RISE_PAT || window == FALL_PAT)));  // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |=> !z_o);  // R7
  AST_FRESH_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full |-> !z_o);  // R8

endmodule

bind seqdet_dual_mealy seqdet_dual_mealy_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .z_o    (z_o)
);

// File: tb/seqdet_dual_mealy_bench.sv
module seqdet_dual_mealy_bench;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic x_i = 1'b0;
  logic z_o;
  int   checks = 0;
  int   errors = 0;
  logic [2:0] ref_hist;
  int   ref_fill;

  // {x, expected z}: R9 example stream, then a continuation
  localparam logic [1:0] VEC [16] = '{
    2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11, 2'b00,
    2'b00, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00, 2'b00, 2'b01
  };

  always #4 clk_i = ~clk_i;  // 125 MHz

  seqdet_dual_mealy u_seqdet_dual_mealy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .z_o    (z_o)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (z_o !== exp) begin
      errors++;
      $display("FAIL %s: z_o=%0b expected %0b at %0t", req, z_o, exp, $time);
    end
  endtask

  // called 1 ns after a rising edge; returns 1 ns after the next one
  task automatic drive(input logic x, input logic exp, input string req);
    x_i = x;
    #2;
    check(exp, req);
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    ref_hist = '0;
    ref_fill = 0;
  endtask

  task automatic drive_ref(input logic x);
    logic exp;
    exp = (ref_fill >= 3) && ({ref_hist, x} == 4'b0111 || {ref_hist, x} == 4'b1000);
    drive(x, exp, exp ? "R2/R3 random" : "R4 random");
    ref_hist = {ref_hist[1:0], x};
    if (ref_fill < 3) ref_fill++;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: z_o=%0b expected run completion", z_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: output quiet during reset for both input values
    repeat (2) @(posedge clk_i);
    #1;
    x_i = 1'b1; #1; check(1'b0, "R1");
    x_i = 1'b0; #1; check(1'b0, "R1");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;

    // R9 / R2 / R3 / R5: vector table
    foreach (VEC[i]) drive(VEC[i][1], VEC[i][0], "R9");

    // R8: a run of ones straight out of reset is unanchored; R3 on the zeros
    do_reset();
    drive(1'b1, 1'b0, "R8");
    drive(1'b1, 1'b0, "R8");
    drive(1'b1, 1'b0, "R8");
    drive(1'b0, 1'b0, "R4");
    drive(1'b0, 1'b0, "R4");
    drive(1'b0, 1'b1, "R3");

    // R8: reset mid-stream drops the 0,1,1 prefix
    do_reset();
    drive(1'b0, 1'b0, "R8");
    drive(1'b1, 1'b0, "R8");
    drive(1'b1, 1'b0, "R8");
    do_reset();
    drive(1'b1, 1'b0, "R8");

    // R6: combinational response within one cycle, state holds 0,1,1
    do_reset();
    drive(1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, "R6");
    drive(1'b1, 1'b0, "R6");
    x_i = 1'b1; #1; check(1'b1, "R6");
    x_i = 1'b0; #1; check(1'b0, "R6");
    x_i = 1'b1; #1; check(1'b1, "R6");
    @(posedge clk_i); #1;
    // R4: fourth equal bit in a row is no match; R7 no back-to-back pulse
    drive(1'b1, 1'b0, "R4");
    drive(1'b1, 1'b0, "R4");

    // R5: overlapping pair sharing one bit
    do_reset();
    drive(1'b0, 1'b0, "R5");
    drive(1'b1, 1'b0, "R5");
    drive(1'b1, 1'b0, "R5");
    drive(1'b1, 1'b1, "R5");
    drive(1'b0, 1'b0, "R7");
    drive(1'b0, 1'b0, "R5");
    drive(1'b0, 1'b1, "R5");

    // random streams against a shift-register reference
    do_reset();
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      // bias toward long runs so both patterns appear often
      drive_ref(($urandom % 4) != 0 ? ref_hist[0] ^ (($urandom % 3) == 0) : 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule